// File: doc/BRIEF.md
# Ternary Associative Road Matcher

The block is a bank of stored track patterns that finds roads in a stream of detector hits. Every pattern holds one 12-bit word per detector layer. Each word carries a 3-bit mask, and a set mask bit lets the matching low-order hit bit take any value. One entry can therefore cover a coarse region or a single fine position. Hits arrive on one bus per layer, at most one word per bus per clock. Every stored pattern compares every hit on its own layer in the same cycle. A pattern records a sticky flag for each layer that has seen a matching hit during the current event.

When the end-of-event pulse arrives, each pattern whose count of flagged layers reaches the programmed threshold becomes a road. The addresses of these roads are taken into a pending set, and all layer flags are cleared. The roads then leave through a valid/ready port, lowest address first. During that readout, incoming hits and end-of-event pulses are ignored. Pattern contents and the threshold can be written only while the bank is idle. Idle means that no hit has been seen since the last end of event and that no readout is in progress.

Top module: `tam_road_bank`

## Requirements
- R1: After reset, `road_valid` is low, the threshold is 8 (all layers), and the bank is idle and accepts configuration writes.
- R2: A hit word matches a stored layer word when every bit agrees, except that bit i (i = 0, 1, 2) of the hit is ignored when bit i of that layer's don't-care mask is set. A mask of 0 requires an exact 12-bit match.
- R3: Layer k's hit is taken from `hit_words[12*k +: 12]` and is valid when `hit_valid[k]` is high. It is compared only against layer k of every pattern, and all patterns compare it in the same cycle.
- R4: A layer flag stays set until the end of the event. Repeated matching hits on the same layer count once.
- R5: A pattern is a road when its number of flagged layers is at least the threshold. A threshold write of 1 to 8 takes effect. A threshold write of 0 or of 9 to 15 is ignored.
- R6: The end-of-event pulse captures the set of roads and clears every layer flag. Hits presented in the same cycle as the pulse are dropped.
- R7: Roads are presented in ascending address order, one per cycle in which `road_valid` and `road_ready` are both high. The address is held while `road_ready` is low. `road_last` is high on the final road of the event. The first road appears in the cycle after the end-of-event pulse.
- R8: A pattern write sets the value and mask of the layer `cfg_layer` in pattern `cfg_pattern`. Pattern writes and threshold writes are ignored unless the bank is idle.
- R9: While roads are being read out, hits and end-of-event pulses are ignored and leave no layer flags behind.
- R10: An end-of-event pulse with no road produces no `road_valid`, and the bank is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pattern word write strobe |
| cfg_pattern | input | 6 | Pattern address to write |
| cfg_layer | input | 3 | Layer index to write |
| cfg_value | input | 12 | Stored layer word |
| cfg_dc | input | 3 | Don't-care mask for bits 2..0 |
| thr_we | input | 1 | Threshold write strobe |
| thr_value | input | 4 | New threshold, 1 to 8 |
| hit_valid | input | 8 | Per-layer hit strobe |
| hit_words | input | 96 | Per-layer hit words, layer k at bits 12k+11..12k |
| evt_end | input | 1 | End-of-event pulse |
| road_valid | output | 1 | A road address is offered |
| road_ready | input | 1 | Consumer takes the offered road |
| road_addr | output | 6 | Address of the offered road |
| road_last | output | 1 | Offered road is the final one of the event |

## Verification
A corrupted stored word or mask, or a layer flag that is lost or set wrongly, shows up as a missing or extra address in the road list. That error appears as soon as the next end-of-event readout begins, one cycle after the pulse. A fault in the threshold register or in the idle gating only shows once an event is run whose flag count falls near the threshold or whose pattern was rewritten. The bench builds those events on purpose. A fault in the ordering or the handshake shows as a wrong address, a changing address or a misplaced `road_last` within the same readout.

// File: rtl/tam_pkg.sv
package tam_pkg;

    localparam int WORD_W = 12;
    localparam int DC_W   = 3;

    typedef logic [WORD_W-1:0] hit_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic [DC_W-1:0]   dc;
    } layer_entry_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_DRAIN   = 2'd2
    } phase_t;

    // Ternary compare: masked low bits of the hit are ignored.
    function automatic logic ternary_hit(input layer_entry_t e, input hit_word_t h);
        logic [WORD_W-1:0] care;
        care = ~{{(WORD_W-DC_W){1'b0}}, e.dc};
        return ((h ^ e.value) & care) == '0;
    endfunction

endpackage

// File: rtl/tam_layer_cell.sv
module tam_layer_cell
    import tam_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  layer_entry_t wr_entry,
    input  logic         hit_valid,
    input  hit_word_t    hit_word,
    input  logic         seen_clr,
    output logic         seen
);

    layer_entry_t entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= '0;
        end else if (wr_en) begin
            entry <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || seen_clr) begin
            seen <= 1'b0;
        end else if (hit_valid && ternary_hit(entry, hit_word)) begin
            seen <= 1'b1;
        end
    end

    // R4
    sticky_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && !seen_clr) |=> seen);

endmodule

// File: rtl/tam_pattern_row.sv
module tam_pattern_row
    import tam_pkg::*;
#(
    parameter int N_LAYERS = 8,
    localparam int LAYER_W = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1,
    localparam int THR_W   = $clog2(N_LAYERS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [LAYER_W-1:0]         wr_layer,
    input  layer_entry_t               wr_entry,
    input  logic [N_LAYERS-1:0]        hit_valid,
    input  logic [N_LAYERS*WORD_W-1:0] hit_words,
    input  logic                       seen_clr,
    input  logic [THR_W-1:0]           threshold,
    output logic                       matched
);

    logic [N_LAYERS-1:0] seen;
    logic [THR_W-1:0]    seen_cnt;

    for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
        tam_layer_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_layer == LAYER_W'(l))),
            .wr_entry (wr_entry),
            .hit_valid(hit_valid[l]),
            .hit_word (hit_words[l*WORD_W +: WORD_W]),
            .seen_clr (seen_clr),
            .seen     (seen[l])
        );
    end

    always_comb begin
        seen_cnt = '0;
        for (int i = 0; i < N_LAYERS; i++) begin
            seen_cnt = seen_cnt + THR_W'(seen[i]);
        end
    end

    assign matched = (seen_cnt >= threshold);

endmodule

// File: rtl/tam_road_encoder.sv
module tam_road_encoder #(
    parameter int N_PATTERNS = 64,
    localparam int ADDR_W = (N_PATTERNS > 1) ? $clog2(N_PATTERNS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [N_PATTERNS-1:0] load_vec,
    input  logic                  ready,
    output logic                  valid,
    output logic [ADDR_W-1:0]     addr,
    output logic                  last
);

    logic [N_PATTERNS-1:0] pending;
    logic [N_PATTERNS-1:0] rest;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (load) begin
            pending <= load_vec;
        end else if (valid && ready) begin
            pending[addr] <= 1'b0;
        end
    end

    always_comb begin
        addr = '0;
        for (int i = N_PATTERNS - 1; i >= 0; i--) begin
            if (pending[i]) addr = ADDR_W'(i);
        end
    end

    assign rest  = pending & (pending - 1'b1);
    assign valid = |pending;
    assign last  = valid && (rest == '0);

    // R7
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(addr)));

    // R7
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && !last) |=> (valid && (addr > $past(addr))));

endmodule

// File: rtl/tam_road_bank.sv
module tam_road_bank
    import tam_pkg::*;
#(
    parameter int N_PATTERNS = 64,
    parameter int N_LAYERS   = 8,
    localparam int ADDR_W  = (N_PATTERNS > 1) ? $clog2(N_PATTERNS) : 1,
    localparam int LAYER_W = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1,
    localparam int THR_W   = $clog2(N_LAYERS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_pattern,
    input  logic [LAYER_W-1:0]         cfg_layer,
    input  logic [WORD_W-1:0]          cfg_value,
    input  logic [DC_W-1:0]            cfg_dc,
    input  logic                       thr_we,
    input  logic [THR_W-1:0]           thr_value,
    input  logic [N_LAYERS-1:0]        hit_valid,
    input  logic [N_LAYERS*WORD_W-1:0] hit_words,
    input  logic                       evt_end,
    output logic                       road_valid,
    input  logic                       road_ready,
    output logic [ADDR_W-1:0]          road_addr,
    output logic                       road_last
);

    phase_t                phase;
    logic [THR_W-1:0]      threshold;
    logic [N_PATTERNS-1:0] matched;
    logic [N_LAYERS-1:0]   hit_accept;
    logic                  end_accept;
    logic                  cfg_take;
    logic                  thr_ok;
    layer_entry_t          cfg_entry;
    logic                  is_idle;
    logic                  is_drain;

    assign is_idle    = (phase == PH_IDLE);
    assign is_drain   = (phase == PH_DRAIN);
    assign hit_accept = hit_valid & {N_LAYERS{!is_drain && !evt_end}};
    assign end_accept = evt_end && !is_drain;
    assign cfg_take   = cfg_we && is_idle;
    assign thr_ok     = (thr_value != '0) && (thr_value <= THR_W'(N_LAYERS));
    assign cfg_entry  = '{value: cfg_value, dc: cfg_dc};

    always_ff @(posedge clk) begin
        if (rst) begin
            threshold <= THR_W'(N_LAYERS);
        end else if (thr_we && is_idle && thr_ok) begin
            threshold <= thr_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (|hit_accept) phase <= PH_COLLECT;
                end
                PH_COLLECT: begin
                    if (end_accept) phase <= (|matched) ? PH_DRAIN : PH_IDLE;
                end
                PH_DRAIN: begin
                    if (road_valid && road_ready && road_last) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    for (genvar p = 0; p < N_PATTERNS; p++) begin : g_row
        tam_pattern_row #(
            .N_LAYERS(N_LAYERS)
        ) row_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cfg_take && (cfg_pattern == ADDR_W'(p))),
            .wr_layer (cfg_layer),
            .wr_entry (cfg_entry),
            .hit_valid(hit_accept),
            .hit_words(hit_words),
            .seen_clr (end_accept),
            .threshold(threshold),
            .matched  (matched[p])
        );
    end

    tam_road_encoder #(
        .N_PATTERNS(N_PATTERNS)
    ) enc_i (
        .clk     (clk),
        .rst     (rst),
        .load    (end_accept),
        .load_vec(matched),
        .ready   (road_ready),
        .valid   (road_valid),
        .addr    (road_addr),
        .last    (road_last)
    );

    // R5
    thr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (threshold != '0) && (threshold <= THR_W'(N_LAYERS)));

    // R8
    thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_idle && thr_we) |=> $stable(threshold));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_idle |-> !road_valid);

    // R9
    drain_clean_chk: assert property (@(posedge clk) disable iff (rst)
        is_drain |-> (matched == '0));

endmodule

// File: tb/tam_road_bank_tb_top.sv
module tam_road_bank_tb_top;

    localparam int NP = 64;
    localparam int NL = 8;
    localparam int W  = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [5:0]      cfg_pattern = '0;
    logic [2:0]      cfg_layer = '0;
    logic [W-1:0]    cfg_value = '0;
    logic [2:0]      cfg_dc = '0;
    logic            thr_we = 1'b0;
    logic [3:0]      thr_value = '0;
    logic [NL-1:0]   hit_valid = '0;
    logic [NL*W-1:0] hit_words = '0;
    logic            evt_end = 1'b0;
    logic            road_valid;
    logic            road_ready = 1'b0;
    logic [5:0]      road_addr;
    logic            road_last;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [W-1:0] m_val  [NP][NL];
    logic [2:0]   m_dc   [NP][NL];
    bit           m_seen [NP][NL];
    int           m_thr;

    always #4 clk = ~clk;

    tam_road_bank #(.N_PATTERNS(NP), .N_LAYERS(NL)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_pattern(cfg_pattern), .cfg_layer(cfg_layer),
        .cfg_value(cfg_value), .cfg_dc(cfg_dc),
        .thr_we(thr_we), .thr_value(thr_value),
        .hit_valid(hit_valid), .hit_words(hit_words), .evt_end(evt_end),
        .road_valid(road_valid), .road_ready(road_ready),
        .road_addr(road_addr), .road_last(road_last)
    );

    function automatic bit ref_match(logic [W-1:0] v, logic [2:0] d, logic [W-1:0] h);
        for (int i = 0; i < W; i++) begin
            if (i < 3 && d[i]) continue;
            if (v[i] !== h[i]) return 0;
        end
        return 1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_entry(int p, int l, logic [W-1:0] v, logic [2:0] d, bit take);
        cfg_we = 1'b1; cfg_pattern = 6'(p); cfg_layer = 3'(l); cfg_value = v; cfg_dc = d;
        if (take) begin m_val[p][l] = v; m_dc[p][l] = d; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_thr(int v, bit idle);
        thr_we = 1'b1; thr_value = 4'(v);
        if (idle && v >= 1 && v <= NL) m_thr = v;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic send_hits(logic [NL-1:0] v, logic [NL*W-1:0] w);
        hit_valid = v; hit_words = w;
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++)
                if (v[l] && ref_match(m_val[p][l], m_dc[p][l], w[l*W +: W])) m_seen[p][l] = 1;
        @(negedge clk);
        hit_valid = '0;
    endtask

    // Pulse end of event (optionally with dropped hits), then drain and compare.
    task automatic end_and_drain(string tag, bit disturb, logic [NL-1:0] ev_v, logic [NL*W-1:0] ev_w);
        int exp_q[$];
        logic [NL*W-1:0] dw;
        evt_end = 1'b1; hit_valid = ev_v; hit_words = ev_w;
        for (int p = 0; p < NP; p++) begin
            int c = 0;
            for (int l = 0; l < NL; l++) begin
                if (m_seen[p][l]) c++;
                m_seen[p][l] = 0;
            end
            if (c >= m_thr) exp_q.push_back(p);
        end
        @(negedge clk);
        evt_end = 1'b0; hit_valid = '0;
        for (int k = 0; k < exp_q.size(); k++) begin
            if (disturb && k == 0) begin
                for (int l = 0; l < NL; l++) dw[l*W +: W] = m_val[5][l];
                hit_valid = '1; hit_words = dw; evt_end = 1'b1;
                chk("R9", {tag, " valid during disturb"}, int'(road_valid), 1);
                @(negedge clk);
                hit_valid = '0; evt_end = 1'b0;
            end
            for (int s = 0; s < int'($urandom_range(0, 2)); s++) begin
                chk("R7", {tag, " stalled addr"}, int'(road_addr), exp_q[k]);
                @(negedge clk);
            end
            chk("R7", {tag, " valid"}, int'(road_valid), 1);
            chk("R7", {tag, " addr"}, int'(road_addr), exp_q[k]);
            chk("R7", {tag, " last"}, int'(road_last), int'(k == exp_q.size() - 1));
            road_ready = 1'b1;
            @(negedge clk);
            road_ready = 1'b0;
        end
        chk("R10", {tag, " no valid after drain"}, int'(road_valid), 0);
    endtask

    task automatic random_event(string tag);
        logic [NL-1:0]   v;
        logic [NL*W-1:0] w;
        int ncyc = $urandom_range(3, 10);
        for (int c = 0; c < ncyc; c++) begin
            for (int l = 0; l < NL; l++) begin
                int p = $urandom_range(0, NP - 1);
                v[l] = ($urandom_range(0, 9) < 7);
                if ($urandom_range(0, 4) == 0) w[l*W +: W] = W'($urandom);
                else w[l*W +: W] = m_val[p][l] ^ W'($urandom_range(0, 7));
            end
            send_hits(v, w);
        end
        end_and_drain(tag, 0, '0, '0);
    endtask

    function automatic logic [NL*W-1:0] one_word(int l, logic [W-1:0] h);
        logic [NL*W-1:0] w = '0;
        w[l*W +: W] = h;
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NL*W-1:0] w7;
        process::self().srandom(32'd1234);
        m_thr = NL;
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) begin
                m_val[p][l] = '0; m_dc[p][l] = '0; m_seen[p][l] = 0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "road_valid after reset", int'(road_valid), 0);

        // R1 / R8: bank is idle after reset, so loads take effect
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++)
                write_entry(p, l, W'($urandom), 3'($urandom_range(0, 7)), 1);

        // R1: reset threshold is all layers; seven of eight layers is not enough
        w7 = '0;
        for (int l = 0; l < NL; l++) w7[l*W +: W] = m_val[10][l];
        send_hits(8'h7F, w7);
        end_and_drain("R1 seven layers", 0, '0, '0);
        send_hits(8'hFF, w7);
        end_and_drain("R1 eight layers", 0, '0, '0);

        // R2: ternary compare on layer 0 of pattern 3
        write_thr(1, 1);
        write_entry(3, 0, 12'hAB0, 3'b101, 1);
        send_hits(8'h01, one_word(0, 12'hAB5));
        end_and_drain("R2 masked bits", 0, '0, '0);
        send_hits(8'h01, one_word(0, 12'hAB2));
        end_and_drain("R2 unmasked bit", 0, '0, '0);
        write_entry(3, 0, 12'hAB0, 3'b000, 1);
        send_hits(8'h01, one_word(0, 12'hAB1));
        end_and_drain("R2 exact miss", 0, '0, '0);
        send_hits(8'h01, one_word(0, 12'hAB0));
        end_and_drain("R2 exact hit", 0, '0, '0);

        // R3: same word on another layer bus
        send_hits(8'h02, one_word(1, 12'hAB0));
        end_and_drain("R3 wrong bus", 0, '0, '0);

        // R4: repeated hits on one layer count once
        write_thr(2, 1);
        for (int i = 0; i < 3; i++) send_hits(8'h01, one_word(0, 12'hAB0));
        end_and_drain("R4 repeat", 0, '0, '0);

        // R8: writes during an event are ignored
        write_thr(1, 1);
        send_hits(8'h20, one_word(5, 12'h5A5));
        write_entry(3, 0, 12'h000, 3'b000, 0);
        write_thr(8, 0);
        send_hits(8'h01, one_word(0, 12'hAB0));
        end_and_drain("R8 busy writes", 0, '0, '0);

        // R9: hits and end pulses during readout are ignored
        send_hits(8'h01, one_word(0, 12'hAB0));
        end_and_drain("R9 disturb", 1, '0, '0);
        end_and_drain("R9 empty after disturb", 0, '0, '0);

        // R6: hits together with the end pulse are dropped
        end_and_drain("R6 same-cycle hits", 0, 8'h01, one_word(0, 12'hAB0));
        end_and_drain("R6 next event", 0, '0, '0);

        // R10: empty event leaves bank idle at once; R5 invalid thresholds ignored
        write_thr(0, 1);
        send_hits(8'h01, one_word(0, 12'hAB0));
        end_and_drain("R5 threshold zero ignored", 0, '0, '0);
        write_thr(12, 1);
        send_hits(8'h01, one_word(0, 12'hAB0));
        end_and_drain("R5 threshold twelve ignored", 0, '0, '0);

        // R5 / R7: constrained random events with random thresholds
        for (int e = 0; e < 150; e++) begin
            if ($urandom_range(0, 2) == 0) write_thr($urandom_range(0, 15), 1);
            random_event("R5 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule